// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Channel

This block is a single capture/compare channel that sits beside a shared 16-bit free-running counter. The counter itself lives elsewhere. The channel receives the counter value, a one-cycle tick that marks each counter advance, and an input pin that is already synchronised. It drives an output pin, a sticky event flag, a reset request and its 16-bit channel register.

A configuration write picks the channel's behaviour:
- idle;
- edge capture;
- software timer;
- toggle-on-match output;
- pulse width modulation at 8, 9, 10, 11 or 16 bits;
- square-wave frequency output;
- watchdog, when the channel is built with that option.

A channel built with the watchdog option leaves reset already running as a watchdog. Software must keep rewriting its register to hold off the reset request.

All matches use the counter value present in a cycle where the tick is high. Every output is registered, so it changes at the clock edge that ends the event cycle.

Top module: `cc_channel`

## Requirements
- R1: After reset, with the watchdog option built in (the default), the mode is watchdog, `ccr_o` is 16'h00FF, and `pin_out`, `flag_o` and `wdt_rst_o` are 0.
- R2: In capture mode (`cfg_mode` 1), a selected edge of `pin_in` copies `cnt_val` into `ccr_o` and sets the flag. `cfg_edge` selects the edges: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. Edges that are not selected change nothing.
- R3: When a capture and a register write (`wr_en`) fall in the same cycle, the captured counter value wins.
- R4: In software timer mode (`cfg_mode` 2), the flag sets only in a tick cycle where `cnt_val` equals `ccr_o`. The output pin does not change.
- R5: In toggle mode (`cfg_mode` 3), each tick cycle with `cnt_val` equal to `ccr_o` inverts `pin_out` and sets the flag.
- R6: In PWM mode (`cfg_mode` 4), `cfg_res` selects the width N: 0 gives 8 bits, 1 gives 9, 2 gives 10, 3 gives 11, and any other value gives 16. On a tick where the low N counter bits are all ones, `pin_out` goes high and the flag sets. On a tick where those bits equal the low N bits of the active compare value, `pin_out` goes low.
- R7: In PWM mode, a write to `ccr_o` takes effect only at the next rollover of the low N bits, or at a configuration write. Until then the previous compare value still drives the falling edge.
- R8: In PWM mode, when the rollover and the compare match fall on the same tick, the rollover wins and `pin_out` is high.
- R9: In frequency mode (`cfg_mode` 5), a tick where `cnt_val[7:0]` equals `ccr_o[7:0]` inverts `pin_out`, sets the flag, and adds `ccr_o[15:8]` to `ccr_o[7:0]` (modulo 256).
- R10: In watchdog mode (`cfg_mode` 6), a tick where `cnt_val[15:8]` equals `ccr_o[7:0]` raises `wdt_rst_o`. It stays high until reset, and no match occurs without a tick.
- R11: In watchdog mode, a register write loads `ccr_o[7:0]` with `cnt_val[15:8] + wr_data[7:0]` and `ccr_o[15:8]` with `wr_data[15:8]`. This restarts the timeout window.
- R12: `flag_clr` clears the flag, except in a cycle where an event sets it; then the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_tick | input | 1 | Counter advance strobe |
| pin_in | input | 1 | Synchronised capture input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code (0 idle .. 6 watchdog) |
| cfg_edge | input | 2 | Capture edge select |
| cfg_res | input | 3 | PWM resolution code |
| wr_en | input | 1 | Channel register write strobe |
| wr_data | input | 16 | Channel register write data |
| flag_clr | input | 1 | Flag clear strobe |
| ccr_o | output | 16 | Channel register |
| pin_out | output | 1 | Output pin |
| flag_o | output | 1 | Sticky event flag |
| wdt_rst_o | output | 1 | Sticky reset request |

## Verification
Three pairs of events can fall in the same cycle, and each is checked by the value it leaves behind:
- **Capture and write.** A register write is driven on the very edge that triggers a capture. The bench expects the counter value in `ccr_o`, not the written data.
- **Rollover and match in PWM.** The compare value is set to all ones, so the rollover and the match hit on one tick. The bench expects `pin_out` to stay high, because a win for the match would drive it low.
- **Flag set and clear.** A flag clear is driven in the same cycle as a capture edge. The bench expects the flag to read 1 afterwards.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        MODE_IDLE   = 3'd0,
        MODE_CAP    = 3'd1,
        MODE_TIMER  = 3'd2,
        MODE_TOGGLE = 3'd3,
        MODE_PWM    = 3'd4,
        MODE_FREQ   = 3'd5,
        MODE_WDT    = 3'd6
    } mode_e;

    // Mask of the low counter bits that form one PWM period.
    function automatic logic [CNT_W-1:0] res_mask(input logic [2:0] res);
        case (res)
            3'd0:    res_mask = 16'h00FF;
            3'd1:    res_mask = 16'h01FF;
            3'd2:    res_mask = 16'h03FF;
            3'd3:    res_mask = 16'h07FF;
            default: res_mask = 16'hFFFF;
        endcase
    endfunction

    // Legal mode from a raw code; unsupported codes fall back to idle.
    function automatic mode_e decode_mode(input logic [2:0] code, input bit wdt_ok);
        case (code)
            3'd1:    decode_mode = MODE_CAP;
            3'd2:    decode_mode = MODE_TIMER;
            3'd3:    decode_mode = MODE_TOGGLE;
            3'd4:    decode_mode = MODE_PWM;
            3'd5:    decode_mode = MODE_FREQ;
            3'd6:    decode_mode = wdt_ok ? MODE_WDT : MODE_IDLE;
            default: decode_mode = MODE_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/cc_edge.sv
module cc_edge (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin;
    end

    // sel[0]: rising edge, sel[1]: falling edge
    assign hit = (sel[0] & pin & ~prev_q) | (sel[1] & ~pin & prev_q);
endmodule

// File: rtl/cc_pwm.sv
module cc_pwm
    import cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    input  logic [2:0]       res,
    input  logic [CNT_W-1:0] shadow,
    output logic             roll,
    output logic             fall
);
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] low;

    assign mask = res_mask(res);
    assign low  = cnt & mask;
    assign roll = active & tick & (low == mask);
    assign fall = active & tick & ~roll & (low == (cmp_q & mask));

    // The active compare value follows the shadow only at period boundaries.
    always_ff @(posedge clk) begin
        if (rst)              cmp_q <= '0;
        else if (load | roll) cmp_q <= shadow;
    end
endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter bit                HAS_WDT  = 1'b1,
    parameter logic [BYTE_W-1:0] WDT_INIT = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_tick,
    input  logic             pin_in,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_mode,
    input  logic [1:0]       cfg_edge,
    input  logic [2:0]       cfg_res,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] ccr_o,
    output logic             pin_out,
    output logic             flag_o,
    output logic             wdt_rst_o
);
    localparam mode_e            RST_MODE = HAS_WDT ? MODE_WDT : MODE_IDLE;
    localparam logic [CNT_W-1:0] RST_CCR  = HAS_WDT ? {{(CNT_W-BYTE_W){1'b0}}, WDT_INIT} : '0;

    mode_e            mode_q;
    logic [1:0]       edge_q;
    logic [2:0]       res_q;
    logic [CNT_W-1:0] ccr_q;
    logic             pin_q, flag_q, wdt_q;

    logic edge_hit, cap_hit, full_match, freq_match, wdt_hit;
    logic pwm_roll, pwm_fall, flag_set;

    cc_edge u_edge (
        .clk (clk),
        .rst (rst),
        .pin (pin_in),
        .sel (edge_q),
        .hit (edge_hit)
    );

    cc_pwm u_pwm (
        .clk    (clk),
        .rst    (rst),
        .active (mode_q == MODE_PWM),
        .tick   (cnt_tick),
        .load   (cfg_we),
        .cnt    (cnt_val),
        .res    (res_q),
        .shadow (ccr_q),
        .roll   (pwm_roll),
        .fall   (pwm_fall)
    );

    assign cap_hit    = (mode_q == MODE_CAP) && edge_hit;
    assign full_match = cnt_tick && (cnt_val == ccr_q);
    assign freq_match = cnt_tick && (cnt_val[BYTE_W-1:0] == ccr_q[BYTE_W-1:0]);

    generate
        if (HAS_WDT) begin : g_wdt
            assign wdt_hit = (mode_q == MODE_WDT) && cnt_tick &&
                             (cnt_val[CNT_W-1:BYTE_W] == ccr_q[BYTE_W-1:0]);
        end else begin : g_no_wdt
            assign wdt_hit = 1'b0;
        end
    endgenerate

    assign flag_set = cap_hit
                    | (((mode_q == MODE_TIMER) || (mode_q == MODE_TOGGLE)) && full_match)
                    | pwm_roll
                    | ((mode_q == MODE_FREQ) && freq_match);

    // Configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RST_MODE;
            edge_q <= 2'b01;
            res_q  <= 3'd0;
        end else if (cfg_we) begin
            mode_q <= decode_mode(cfg_mode, HAS_WDT);
            edge_q <= cfg_edge;
            res_q  <= cfg_res;
        end
    end

    // Channel register: capture > write > frequency advance
    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= RST_CCR;
        end else if (cap_hit) begin
            ccr_q <= cnt_val;
        end else if (wr_en) begin
            if (HAS_WDT && mode_q == MODE_WDT)
                ccr_q <= {wr_data[CNT_W-1:BYTE_W],
                          cnt_val[CNT_W-1:BYTE_W] + wr_data[BYTE_W-1:0]};
            else
                ccr_q <= wr_data;
        end else if (mode_q == MODE_FREQ && freq_match) begin
            ccr_q[BYTE_W-1:0] <= ccr_q[BYTE_W-1:0] + ccr_q[CNT_W-1:BYTE_W];
        end
    end

    // Output pin, flag and reset request
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b0;
            flag_q <= 1'b0;
            wdt_q  <= 1'b0;
        end else begin
            case (mode_q)
                MODE_TOGGLE: if (full_match) pin_q <= ~pin_q;
                MODE_PWM: begin
                    if (pwm_roll)      pin_q <= 1'b1;
                    else if (pwm_fall) pin_q <= 1'b0;
                end
                MODE_FREQ:   if (freq_match) pin_q <= ~pin_q;
                default: ;
            endcase
            if (flag_set)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            if (wdt_hit)       wdt_q  <= 1'b1;
        end
    end

    assign ccr_o     = ccr_q;
    assign pin_out   = pin_q;
    assign flag_o    = flag_q;
    assign wdt_rst_o = wdt_q;
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk
    import cc_pkg::*;
#(
    parameter bit HAS_WDT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_tick,
    input logic             pin_in,
    input logic             flag_clr,
    input logic [CNT_W-1:0] ccr_o,
    input logic             pin_out,
    input logic             flag_o,
    input logic             wdt_rst_o,
    input mode_e            mode_q,
    input logic [1:0]       edge_q,
    input logic [2:0]       res_q
);
    p_wdt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_o |=> wdt_rst_o);

    p_wdt_hit_r10: assert property (@(posedge clk) disable iff (rst)
        (HAS_WDT && mode_q == MODE_WDT && cnt_tick &&
         cnt_val[CNT_W-1:BYTE_W] == ccr_o[BYTE_W-1:0]) |=> wdt_rst_o);

    p_capture_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_CAP && edge_q[0] && $rose(pin_in))
        |=> (ccr_o == $past(cnt_val)) && flag_o);

    p_timer_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TIMER && cnt_tick && cnt_val == ccr_o) |=> flag_o);

    p_timer_pin_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TIMER) |=> $stable(pin_out));

    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TOGGLE && cnt_tick && cnt_val == ccr_o)
        |=> pin_out != $past(pin_out));

    p_pwm_roll_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PWM && cnt_tick &&
         (cnt_val & res_mask(res_q)) == res_mask(res_q)) |=> pin_out && flag_o);

    p_flag_clr_r12: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IDLE && flag_clr) |=> !flag_o);
endmodule

bind cc_channel cc_channel_chk #(.HAS_WDT(HAS_WDT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_val   (cnt_val),
    .cnt_tick  (cnt_tick),
    .pin_in    (pin_in),
    .flag_clr  (flag_clr),
    .ccr_o     (ccr_o),
    .pin_out   (pin_out),
    .flag_o    (flag_o),
    .wdt_rst_o (wdt_rst_o),
    .mode_q    (mode_q),
    .edge_q    (edge_q),
    .res_q     (res_q)
);

// File: tb/cc_channel_bench.sv
module cc_channel_bench;
    localparam int CLK_P  = 10;
    localparam int N_VEC  = 8;
    localparam int WD_CYC = 20000;

    // PWM 8-bit walk, compare value 0x40: {cnt_val, tick, expected pin}
    localparam logic [17:0] PWM_VEC [N_VEC] = '{
        {16'h00FF, 1'b1, 1'b1},
        {16'h0010, 1'b1, 1'b1},
        {16'h0040, 1'b1, 1'b0},
        {16'h0041, 1'b1, 1'b0},
        {16'h0140, 1'b1, 1'b0},
        {16'h01FF, 1'b1, 1'b1},
        {16'h0040, 1'b0, 1'b1},
        {16'h0040, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = '0;
    logic        cnt_tick = 1'b0;
    logic        pin_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic [1:0]  cfg_edge = '0;
    logic [2:0]  cfg_res = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] ccr_o;
    logic        pin_out, flag_o, wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cc_channel u_cc_channel (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .pin_in(pin_in), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_edge(cfg_edge), .cfg_res(cfg_res), .wr_en(wr_en),
        .wr_data(wr_data), .flag_clr(flag_clr), .ccr_o(ccr_o),
        .pin_out(pin_out), .flag_o(flag_o), .wdt_rst_o(wdt_rst_o)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // One clock: inputs already set, strobes dropped afterwards.
    task automatic step();
        @(posedge clk);
        #1;
        cnt_tick = 1'b0; cfg_we = 1'b0; wr_en = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
    endtask

    task automatic tick_at(input logic [15:0] v);
        cnt_val = v; cnt_tick = 1'b1; step();
    endtask

    task automatic cfg(input logic [2:0] m, input logic [1:0] e, input logic [2:0] r);
        cfg_mode = m; cfg_edge = e; cfg_res = r; cfg_we = 1'b1; step();
    endtask

    task automatic write(input logic [15:0] d);
        wr_data = d; wr_en = 1'b1; step();
    endtask

    initial begin
        #(CLK_P/2 + 1);
        do_reset();
        // R1 reset state
        chk("R1 ccr", ccr_o, 16'h00FF);
        chk("R1 pin", {15'd0, pin_out}, 16'd0);
        chk("R1 flag", {15'd0, flag_o}, 16'd0);
        chk("R1 wdt", {15'd0, wdt_rst_o}, 16'd0);

        // R10 watchdog timeout
        tick_at(16'hFE00);
        chk("R10 no early request", {15'd0, wdt_rst_o}, 16'd0);
        cnt_val = 16'hFF00; step();
        chk("R10 no match without tick", {15'd0, wdt_rst_o}, 16'd0);
        tick_at(16'hFF00);
        chk("R10 request on match", {15'd0, wdt_rst_o}, 16'd1);
        tick_at(16'h0000);
        chk("R10 request sticky", {15'd0, wdt_rst_o}, 16'd1);

        // R11 restart by write
        do_reset();
        cnt_val = 16'h1000; write(16'h0005);
        chk("R11 reload", ccr_o, 16'h0015);
        tick_at(16'h1400);
        chk("R11 before window", {15'd0, wdt_rst_o}, 16'd0);
        write(16'h0005);
        chk("R11 second reload", ccr_o, 16'h0019);
        tick_at(16'h1500);
        chk("R11 old limit passed", {15'd0, wdt_rst_o}, 16'd0);
        tick_at(16'h1900);
        chk("R11 new limit", {15'd0, wdt_rst_o}, 16'd1);

        // R2 capture with edge selection
        do_reset();
        cfg(3'd1, 2'b01, 3'd0);
        pin_in = 1'b1; cnt_val = 16'h1234; step();
        chk("R2 rising capture", ccr_o, 16'h1234);
        chk("R2 rising flag", {15'd0, flag_o}, 16'd1);
        flag_clr = 1'b1; step();
        chk("R12 flag cleared", {15'd0, flag_o}, 16'd0);
        pin_in = 1'b0; cnt_val = 16'h2222; step();
        chk("R2 falling ignored", ccr_o, 16'h1234);
        chk("R2 falling no flag", {15'd0, flag_o}, 16'd0);
        cfg(3'd1, 2'b10, 3'd0);
        pin_in = 1'b1; cnt_val = 16'h3333; step();
        chk("R2 rising ignored", ccr_o, 16'h1234);
        pin_in = 1'b0; cnt_val = 16'h4444; step();
        chk("R2 falling capture", ccr_o, 16'h4444);
        cfg(3'd1, 2'b11, 3'd0);
        pin_in = 1'b1; cnt_val = 16'h5555; step();
        chk("R2 both edges", ccr_o, 16'h5555);
        cfg(3'd1, 2'b00, 3'd0);
        pin_in = 1'b0; cnt_val = 16'h6666; step();
        chk("R2 no edges", ccr_o, 16'h5555);

        // R3 capture beats write
        cfg(3'd1, 2'b11, 3'd0);
        pin_in = 1'b1; cnt_val = 16'h7777; wr_data = 16'hAAAA; wr_en = 1'b1; step();
        chk("R3 capture wins", ccr_o, 16'h7777);
        write(16'hAAAA);
        chk("R3 plain write", ccr_o, 16'hAAAA);

        // R12 set beats clear
        flag_clr = 1'b1; step();
        chk("R12 clear", {15'd0, flag_o}, 16'd0);
        pin_in = 1'b0; cnt_val = 16'h0001; flag_clr = 1'b1; step();
        chk("R12 set wins", {15'd0, flag_o}, 16'd1);

        // R4 software timer
        cfg(3'd2, 2'b00, 3'd0);
        write(16'h0300);
        flag_clr = 1'b1; step();
        cnt_val = 16'h0300; step();
        chk("R4 no tick no flag", {15'd0, flag_o}, 16'd0);
        tick_at(16'h0301);
        chk("R4 mismatch no flag", {15'd0, flag_o}, 16'd0);
        tick_at(16'h0300);
        chk("R4 match flag", {15'd0, flag_o}, 16'd1);
        chk("R4 pin unchanged", {15'd0, pin_out}, 16'd0);

        // R5 toggle
        cfg(3'd3, 2'b00, 3'd0);
        tick_at(16'h0300);
        chk("R5 toggle high", {15'd0, pin_out}, 16'd1);
        tick_at(16'h0300);
        chk("R5 toggle low", {15'd0, pin_out}, 16'd0);
        tick_at(16'h0301);
        chk("R5 mismatch holds", {15'd0, pin_out}, 16'd0);

        // R9 frequency output
        cfg(3'd5, 2'b00, 3'd0);
        write(16'h0310);
        tick_at(16'h0010);
        chk("R9 toggle", {15'd0, pin_out}, 16'd1);
        chk("R9 advance", ccr_o, 16'h0313);
        tick_at(16'h0012);
        chk("R9 hold pin", {15'd0, pin_out}, 16'd1);
        chk("R9 hold ccr", ccr_o, 16'h0313);
        tick_at(16'h5513);
        chk("R9 second toggle", {15'd0, pin_out}, 16'd0);
        chk("R9 second advance", ccr_o, 16'h0316);

        // R6 PWM 8-bit walk
        write(16'h0040);
        cfg(3'd4, 2'b00, 3'd0);
        for (int i = 0; i < N_VEC; i++) begin
            cnt_val = PWM_VEC[i][17:2]; cnt_tick = PWM_VEC[i][1]; step();
            chk($sformatf("R6 pwm8 vec %0d", i), {15'd0, pin_out}, {15'd0, PWM_VEC[i][0]});
        end

        // R7 shadow reload
        tick_at(16'h00FF);
        write(16'h0080);
        tick_at(16'h0040);
        chk("R7 old compare used", {15'd0, pin_out}, 16'd0);
        tick_at(16'h00FF);
        tick_at(16'h0040);
        chk("R7 old compare gone", {15'd0, pin_out}, 16'd1);
        tick_at(16'h0080);
        chk("R7 new compare", {15'd0, pin_out}, 16'd0);

        // R8 rollover and match together
        write(16'h00FF);
        tick_at(16'h00FF);
        tick_at(16'h0010);
        flag_clr = 1'b1; step();
        tick_at(16'h00FF);
        chk("R8 rollover wins pin", {15'd0, pin_out}, 16'd1);
        chk("R8 rollover flag", {15'd0, flag_o}, 16'd1);

        // R6 other resolutions
        cfg(3'd4, 2'b00, 3'd1);
        write(16'h0100);
        tick_at(16'h01FF);
        chk("R6 pwm9 rollover", {15'd0, pin_out}, 16'd1);
        tick_at(16'h00FF);
        chk("R6 pwm9 no 8-bit wrap", {15'd0, pin_out}, 16'd1);
        tick_at(16'h0300);
        chk("R6 pwm9 match", {15'd0, pin_out}, 16'd0);
        cfg(3'd4, 2'b00, 3'd4);
        tick_at(16'h01FF);
        chk("R6 pwm16 no 9-bit wrap", {15'd0, pin_out}, 16'd0);
        tick_at(16'hFFFF);
        chk("R6 pwm16 rollover", {15'd0, pin_out}, 16'd1);
        tick_at(16'h0100);
        chk("R6 pwm16 match", {15'd0, pin_out}, 16'd0);
        cfg(3'd4, 2'b00, 3'd2);
        tick_at(16'h01FF);
        chk("R6 pwm10 no 9-bit wrap", {15'd0, pin_out}, 16'd0);
        tick_at(16'h03FF);
        chk("R6 pwm10 rollover", {15'd0, pin_out}, 16'd1);
        cfg(3'd4, 2'b00, 3'd3);
        tick_at(16'h0100);
        tick_at(16'h03FF);
        chk("R6 pwm11 no 10-bit wrap", {15'd0, pin_out}, 16'd0);
        tick_at(16'h07FF);
        chk("R6 pwm11 rollover", {15'd0, pin_out}, 16'd1);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * WD_CYC);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule